// File: doc/BRIEF.md
# Eight-Channel Joinable PWM Generator

This block produces eight pulse-width modulated outputs from one synchronous clock. Every channel owns a counter, a period value and a duty value, and it advances only on cycles where the `tick` enable input is high. A channel counts either as a plain up-counter that wraps (edge mode) or up and then back down (center mode), and it can invert its pin. Any of the four neighbouring channel pairs can be merged into a single channel with a 16-bit period and duty. This gives finer resolution at the cost of one pin.

Software drives the block through a one-cycle write strobe with an address and a byte of data. Period and duty writes land in holding registers. A running channel picks them up only when its current period ends, so a waveform never shows a half-updated cycle. Writes to enable and polarity act at once. A write that changes a channel's counting mode or its pairing restarts that channel's counter.

Top module: `pwm_concat_top`

## Requirements
- R1: While `rstN` is low, and right after it is released, every bit of `pwmOut` is 0. Reset clears every register.
- R2: In edge mode (center bit 0), the counter runs 0 to P−1 on ticks and then wraps. The pin is active while count < D. Channels run independently. Register map: addresses 0–7 hold the period of channels 0–7, addresses 8–15 hold their duty, and address 16 holds the enable mask (bit n = channel n).
- R3: A duty of 0 keeps the pin inactive for the whole period. A duty of D ≥ P in edge mode, or D > P in center mode, keeps it active for the whole period.
- R4: Address 17 holds the invert mask. With bit n = 1, pin n is low while active and high while inactive. With bit n = 0, the pin is high while active.
- R5: Address 18 holds the center mask. With bit n = 1, the counter steps 0,1,…,P,P−1,…,1 and then repeats, so the pin period is 2·P ticks. The pin is active while count < D.
- R6: Address 19, bits 0–3, joins pair k (channels 2k+1:2k). The period becomes {period[2k+1], period[2k]} and the duty becomes {duty[2k+1], duty[2k]}. Channel 2k+1's enable, invert and center bits apply. Each pair joins independently, so 8/0, 6/1, 4/2, 2/3 and 0/4 mixes all arise.
- R7: While pair k is joined, pin 2k stays at its inactive level, which equals invert bit 2k.
- R8: New period and duty values reach a running channel only at the end of its current period. The period in progress keeps the old values.
- R9: A period of 0 holds the pin at its inactive level.
- R10: Counters move only on cycles with `tick` high. With `tick` and `wrEn` both low, the pins do not change on the next edge.
- R11: A channel whose enable bit is 0 holds its pin at its inactive level. Its counter sits at 0, and its holding values load directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; counters advance only when high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address |
| wrData | input | 8 | Register write data |
| pwmOut | output | 8 | PWM pins, bit n = channel n |

## Verification
On every cycle, the assertions check four things. Pins sit at zero in reset. A disabled channel and the low half of a joined pair sit at their inactive level. The pins hold still on any cycle with neither a tick nor a write. The waveform shapes can only be shown by the bench's scenarios. These are the active-time ratios in edge and center mode, the 0% and 100% ends, inversion, the 16-bit joined periods in a mixed 4/2 layout, the deferred pickup of a new duty at the period boundary, the zero period, and a slowed tick.

// File: rtl/pwm_concat_pkg.sv
package pwm_concat_pkg;
  localparam int CH_NUM   = 8;
  localparam int CH_W     = 8;
  localparam int PAIR_NUM = CH_NUM / 2;
  localparam int ADDR_W   = 5;
  localparam int IDX_W    = $clog2(CH_NUM);

  localparam logic [ADDR_W-1:0] ADDR_DUTY0 = ADDR_W'(CH_NUM);
  localparam logic [ADDR_W-1:0] ADDR_EN    = ADDR_W'(2 * CH_NUM);
  localparam logic [ADDR_W-1:0] ADDR_INV   = ADDR_W'(2 * CH_NUM + 1);
  localparam logic [ADDR_W-1:0] ADDR_CTR   = ADDR_W'(2 * CH_NUM + 2);
  localparam logic [ADDR_W-1:0] ADDR_JOIN  = ADDR_W'(2 * CH_NUM + 3);

  typedef struct packed {
    logic [CH_NUM-1:0]   enable;
    logic [CH_NUM-1:0]   invert;
    logic [CH_NUM-1:0]   center;
    logic [CH_NUM-1:0]   restart;
    logic [PAIR_NUM-1:0] joined;
  } pwmCtrl_t;
endpackage

// File: rtl/pwm_concat_regs.sv
module pwm_concat_regs
  import pwm_concat_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [CH_W-1:0]                  wrData,
  output pwmCtrl_t                         ctrlBus,
  output logic [CH_NUM-1:0][CH_W-1:0]      perArr,
  output logic [CH_NUM-1:0][CH_W-1:0]      dutyArr
);
  logic [CH_NUM-1:0]   enReg, invReg, ctrReg;
  logic [PAIR_NUM-1:0] joinReg;
  logic [IDX_W-1:0]    idx;
  logic                perSel, dutySel;

  assign idx     = wrAddr[IDX_W-1:0];
  assign perSel  = wrEn && (wrAddr < ADDR_DUTY0);
  assign dutySel = wrEn && (wrAddr >= ADDR_DUTY0) && (wrAddr < ADDR_EN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perArr  <= '0;
      dutyArr <= '0;
      enReg   <= '0;
      invReg  <= '0;
      ctrReg  <= '0;
      joinReg <= '0;
    end else begin
      if (perSel)  perArr[idx]  <= wrData;
      if (dutySel) dutyArr[idx] <= wrData;
      if (wrEn && wrAddr == ADDR_EN)   enReg   <= wrData[CH_NUM-1:0];
      if (wrEn && wrAddr == ADDR_INV)  invReg  <= wrData[CH_NUM-1:0];
      if (wrEn && wrAddr == ADDR_CTR)  ctrReg  <= wrData[CH_NUM-1:0];
      if (wrEn && wrAddr == ADDR_JOIN) joinReg <= wrData[PAIR_NUM-1:0];
    end
  end

  // restart strobes: a channel whose counting mode or pairing changes starts over
  always_comb begin
    ctrlBus.enable  = enReg;
    ctrlBus.invert  = invReg;
    ctrlBus.center  = ctrReg;
    ctrlBus.joined  = joinReg;
    ctrlBus.restart = '0;
    if (wrEn && wrAddr == ADDR_CTR)
      ctrlBus.restart = wrData[CH_NUM-1:0] ^ ctrReg;
    if (wrEn && wrAddr == ADDR_JOIN)
      for (int k = 0; k < PAIR_NUM; k++)
        if (wrData[k] != joinReg[k]) begin
          ctrlBus.restart[2*k]   = 1'b1;
          ctrlBus.restart[2*k+1] = 1'b1;
        end
  end
endmodule

// File: rtl/pwm_concat_engine.sv
module pwm_concat_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         restart,
  input  logic         enable,
  input  logic         center,
  input  logic [W-1:0] shPer,
  input  logic [W-1:0] shDuty,
  output logic         active
);
  logic [W-1:0] cnt, curPer, curDuty;
  logic         goingDown;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      goingDown <= 1'b0;
      curPer    <= '0;
      curDuty   <= '0;
    end else if (restart || !enable) begin
      cnt       <= '0;
      goingDown <= 1'b0;
      curPer    <= shPer;
      curDuty   <= shDuty;
    end else if (tick) begin
      if (curPer == '0) begin
        cnt     <= '0;
        curPer  <= shPer;
        curDuty <= shDuty;
      end else if (!center) begin
        if (cnt >= curPer - W'(1)) begin
          cnt     <= '0;
          curPer  <= shPer;
          curDuty <= shDuty;
        end else begin
          cnt <= cnt + W'(1);
        end
      end else if (!goingDown) begin
        cnt <= cnt + W'(1);
        if ((cnt + W'(1)) == curPer) goingDown <= 1'b1;
      end else begin
        cnt <= cnt - W'(1);
        if (cnt == W'(1)) begin
          goingDown <= 1'b0;
          curPer    <= shPer;
          curDuty   <= shDuty;
        end
      end
    end
  end

  assign active = enable && (curPer != '0) && (cnt < curDuty);
endmodule

// File: rtl/pwm_concat_dp.sv
module pwm_concat_dp
  import pwm_concat_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tick,
  input  pwmCtrl_t                    ctrlBus,
  input  logic [CH_NUM-1:0][CH_W-1:0] perArr,
  input  logic [CH_NUM-1:0][CH_W-1:0] dutyArr,
  output logic [CH_NUM-1:0]           pwmOut
);
  for (genvar k = 0; k < PAIR_NUM; k++) begin : g_pair
    localparam int LO = 2 * k;
    localparam int HI = 2 * k + 1;
    logic             loActive, hiActive;
    logic [2*CH_W-1:0] hiPer, hiDuty;

    assign hiPer  = ctrlBus.joined[k] ? {perArr[HI], perArr[LO]}   : {{CH_W{1'b0}}, perArr[HI]};
    assign hiDuty = ctrlBus.joined[k] ? {dutyArr[HI], dutyArr[LO]} : {{CH_W{1'b0}}, dutyArr[HI]};

    pwm_concat_engine #(.W(CH_W)) lo_i (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (tick),
      .restart(ctrlBus.restart[LO]),
      .enable (ctrlBus.enable[LO] && !ctrlBus.joined[k]),
      .center (ctrlBus.center[LO]),
      .shPer  (perArr[LO]),
      .shDuty (dutyArr[LO]),
      .active (loActive)
    );

    pwm_concat_engine #(.W(2 * CH_W)) hi_i (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (tick),
      .restart(ctrlBus.restart[HI]),
      .enable (ctrlBus.enable[HI]),
      .center (ctrlBus.center[HI]),
      .shPer  (hiPer),
      .shDuty (hiDuty),
      .active (hiActive)
    );

    assign pwmOut[LO] = loActive ^ ctrlBus.invert[LO];
    assign pwmOut[HI] = hiActive ^ ctrlBus.invert[HI];
  end
endmodule

// File: rtl/pwm_concat_top.sv
module pwm_concat_top
  import pwm_concat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic [4:0]  wrAddr,
  input  logic [7:0]  wrData,
  output logic [7:0]  pwmOut
);
  pwmCtrl_t                    ctrlBus;
  logic [CH_NUM-1:0][CH_W-1:0] perArr, dutyArr;

  pwm_concat_regs regs_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .ctrlBus(ctrlBus),
    .perArr (perArr),
    .dutyArr(dutyArr)
  );

  pwm_concat_dp dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .ctrlBus(ctrlBus),
    .perArr (perArr),
    .dutyArr(dutyArr),
    .pwmOut (pwmOut)
  );
endmodule

// File: rtl/pwm_concat_chk.sv
module pwm_concat_chk
  import pwm_concat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              wrEn,
  input logic [CH_NUM-1:0] pwmOut,
  input pwmCtrl_t          ctrlBus
);
  always @(posedge clk) begin
    if (!rstN) begin
      // R1
      reset_idle_chk: assert (pwmOut == '0);
    end
  end

  // R10
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrEn) |=> $stable(pwmOut));

  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    // R11
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !ctrlBus.enable[n] |-> (pwmOut[n] == ctrlBus.invert[n]));
  end

  for (genvar k = 0; k < PAIR_NUM; k++) begin : g_pair
    // R7
    joined_low_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctrlBus.joined[k] |-> (pwmOut[2*k] == ctrlBus.invert[2*k]));
  end
endmodule

bind pwm_concat_top pwm_concat_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .tick   (tick),
  .wrEn   (wrEn),
  .pwmOut (pwmOut),
  .ctrlBus(ctrlBus)
);

// File: tb/pwm_concat_tb.sv
module pwm_concat_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       tick = 1'b1;
  logic       tickHalf = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] pwmOut;
  int         total = 0;
  int         bad = 0;

  pwm_concat_top dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pwmOut(pwmOut)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tickHalf) tick <= ~tick;
    else          tick <= 1'b1;
  end

  task automatic checkEq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countHigh(input int ch, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      n += int'(pwmOut[ch]);
    end
  endtask

  task automatic clearCfg();
    writeReg(5'd16, 8'h00);
    writeReg(5'd19, 8'h00);
    writeReg(5'd18, 8'h00);
    writeReg(5'd17, 8'h00);
  endtask

  task automatic waitRise(input int ch);
    logic prev;
    prev = pwmOut[ch];
    forever begin
      @(negedge clk);
      if (!prev && pwmOut[ch]) break;
      prev = pwmOut[ch];
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R1 pins in reset", int'(pwmOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 pins after reset", int'(pwmOut), 0);
  endtask

  task automatic testEdge();
    int n0, n1;
    clearCfg();
    writeReg(5'd0, 8'd10); writeReg(5'd8, 8'd3);
    writeReg(5'd1, 8'd10); writeReg(5'd9, 8'd7);
    writeReg(5'd16, 8'h03);
    repeat (20) @(negedge clk);
    fork
      countHigh(0, 100, n0);
      countHigh(1, 100, n1);
    join
    checkEq("R2 edge ch0 10/3", n0, 30);
    checkEq("R2 edge ch1 10/7", n1, 70);
  endtask

  task automatic testExtremes();
    int n;
    clearCfg();
    writeReg(5'd0, 8'd10); writeReg(5'd8, 8'd0);
    writeReg(5'd16, 8'h01);
    repeat (20) @(negedge clk);
    countHigh(0, 100, n);
    checkEq("R3 duty zero", n, 0);
    writeReg(5'd8, 8'd10);
    repeat (25) @(negedge clk);
    countHigh(0, 100, n);
    checkEq("R3 edge full duty", n, 100);
    writeReg(5'd0, 8'd5); writeReg(5'd8, 8'd6);
    writeReg(5'd18, 8'h01);
    repeat (25) @(negedge clk);
    countHigh(0, 100, n);
    checkEq("R3 center full duty", n, 100);
  endtask

  task automatic testInvert();
    int n;
    clearCfg();
    writeReg(5'd0, 8'd10); writeReg(5'd8, 8'd3);
    writeReg(5'd17, 8'h01);
    writeReg(5'd16, 8'h01);
    repeat (20) @(negedge clk);
    countHigh(0, 100, n);
    checkEq("R4 inverted 10/3", n, 70);
  endtask

  task automatic testCenter();
    int n;
    clearCfg();
    writeReg(5'd2, 8'd5); writeReg(5'd10, 8'd2);
    writeReg(5'd18, 8'h04);
    writeReg(5'd16, 8'h04);
    repeat (20) @(negedge clk);
    countHigh(2, 100, n);
    checkEq("R5 center 5/2", n, 30);
  endtask

  task automatic testJoin();
    int n1, n4, n6, n7;
    clearCfg();
    writeReg(5'd0, 8'd200); writeReg(5'd1, 8'd0);
    writeReg(5'd8, 8'd50);  writeReg(5'd9, 8'd0);
    writeReg(5'd6, 8'h90);  writeReg(5'd7, 8'h01);
    writeReg(5'd14, 8'h64); writeReg(5'd15, 8'h00);
    writeReg(5'd4, 8'd10);  writeReg(5'd12, 8'd3);
    writeReg(5'd17, 8'h40);
    writeReg(5'd19, 8'h09);
    writeReg(5'd16, 8'hFF);
    repeat (10) @(negedge clk);
    fork
      countHigh(1, 800, n1);
      countHigh(4, 800, n4);
      countHigh(6, 800, n6);
      countHigh(7, 800, n7);
    join
    checkEq("R6 joined pair0 200/50", n1, 200);
    checkEq("R6 joined pair3 400/100", n7, 200);
    checkEq("R6 unjoined ch4 10/3", n4, 240);
    checkEq("R7 joined low pin idle (inverted)", n6, 800);
  endtask

  task automatic testBuffer();
    int run;
    clearCfg();
    writeReg(5'd0, 8'd10); writeReg(5'd8, 8'd5);
    writeReg(5'd16, 8'h01);
    waitRise(0);
    wrEn = 1'b1; wrAddr = 5'd8; wrData = 8'd9;
    run = 1;
    @(negedge clk);
    wrEn = 1'b0;
    while (pwmOut[0]) begin
      run++;
      @(negedge clk);
    end
    checkEq("R8 current period keeps old duty", run, 5);
    waitRise(0);
    run = 1;
    @(negedge clk);
    while (pwmOut[0]) begin
      run++;
      @(negedge clk);
    end
    checkEq("R8 next period uses new duty", run, 9);
  endtask

  task automatic testZeroPeriod();
    int n;
    clearCfg();
    writeReg(5'd0, 8'd0); writeReg(5'd8, 8'd5);
    writeReg(5'd16, 8'h01);
    repeat (5) @(negedge clk);
    countHigh(0, 50, n);
    checkEq("R9 zero period idle", n, 0);
    writeReg(5'd17, 8'h01);
    countHigh(0, 50, n);
    checkEq("R9 zero period idle inverted", n, 50);
  endtask

  task automatic testTick();
    int n;
    clearCfg();
    writeReg(5'd0, 8'd10); writeReg(5'd8, 8'd3);
    writeReg(5'd16, 8'h01);
    tickHalf = 1'b1;
    repeat (40) @(negedge clk);
    countHigh(0, 200, n);
    tickHalf = 1'b0;
    checkEq("R10 half-rate tick 10/3", n, 60);
  endtask

  task automatic testDisable();
    int n;
    clearCfg();
    writeReg(5'd0, 8'd10); writeReg(5'd8, 8'd5);
    repeat (5) @(negedge clk);
    countHigh(0, 50, n);
    checkEq("R11 disabled pin idle", n, 0);
  endtask

  initial begin
    #1 rstN = 1'b0;
    #60 rstN = 1'b1;
    testReset();
    testEdge();
    testExtremes();
    testInvert();
    testCenter();
    testJoin();
    testBuffer();
    testZeroPeriod();
    testTick();
    testDisable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule